// File: doc/BRIEF.md
# Multi-channel countdown timer bank with APB access

This block is a bank of eight independent 32-bit down-counters behind an APB slave port. Each channel has its own register group at a fixed address stride. Software writes a load count and then enables the channel. The counter then steps down once per timer-clock cycle. When it passes zero it reloads and flags a rollover. In periodic mode it reloads the programmed count. In free-running mode it reloads all ones, which gives software a long window to rearm a one-shot event. Every rollover sets a raw status bit, even when the channel's interrupt is masked. The masked status drives one interrupt output per channel. Reading the channel's end-of-interrupt register clears it.

The counters run on a timer clock that is asynchronous to the bus clock. Configuration crosses into the timer domain through synchronisers, and rollover events cross back as toggles. A current-value read takes a coherent snapshot through a toggle handshake. The bus access is held with wait states until the snapshot arrives, so a read never returns a torn value.

The bus side is a three-state machine. IDLE completes every access in its access phase, except a current-value read. A current-value read in IDLE toggles the request and moves to WAIT (transition "request"). WAIT holds `pready` low until the acknowledge toggle comes back, then latches the snapshot and moves to DONE (transition "capture"). DONE completes the transfer with the held value and returns to IDLE (transition "release"). The bus clock must be faster than the timer clock.

Top module: `apb_countdown_bank`

## Requirements
- R1: After reset, `irq_o` is all zero, the raw status register reads 0, and every channel control register reads 0.
- R2: Address map. Channel n's group starts at n*0x20, with load count at +0x00, current value at +0x04 (read-only), control at +0x08, end-of-interrupt at +0x0C and channel status (masked bit in bit 0) at +0x10. The shared registers are raw status at 0x100 (bit n for channel n), masked status at 0x104 and a version word at 0x10C, which reads 32'h0001_0200.
- R3: Control bit 0 is enable, bit 1 selects periodic (1) or free-running (0), and bit 2 masks the interrupt (1 = masked). A rising edge of enable loads the load count into the counter. While enabled, the counter then decrements by one per timer clock.
- R4: In periodic mode, the timer clock after the counter reads zero reloads the load count and signals a rollover. Rollovers therefore repeat every load+1 timer clocks.
- R5: In free-running mode, the counter reloads 32'hFFFF_FFFF after passing zero, regardless of the load count.
- R6: A rollover sets the channel's raw status bit even while the channel is masked. Masked status equals raw AND NOT mask, and `irq_o[n]` follows channel n's masked status. Unmasking a pending channel raises its interrupt without a new rollover.
- R7: Reading a channel's end-of-interrupt register returns 0 and clears that channel's pending status. It has no effect on the counter.
- R8: A disabled channel holds its counter value, has its pending status cleared, and sets no status.
- R9: A current-value read is stalled with wait states while a snapshot is taken in the timer domain. It returns a value that the counter actually held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Bus-domain reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready; low during snapshot wait |
| tclk | input | 1 | Timer clock, asynchronous to pclk |
| trstn | input | 1 | Timer-domain reset, active low |
| irq_o | output | 8 | Per-channel interrupt, masked status |

## Verification
The bench measures the spacing of successive periodic rollovers against load+1 timer clocks. An off-by-one reload or a missed reload would shift or remove the second interrupt. It runs a masked free-running channel and expects the raw bit set with the output quiet and a reload near all ones. A design that reloaded the load count, or gated raw status with the mask, would fail there. It checks that an end-of-interrupt read leaves the counter still falling, that a disabled channel reads the same value twice and drops its pending bit, and that a current-value read takes several wait states but returns an in-range value. Every bus clock, a monitor checks that no masked or never-enabled channel drives its interrupt.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_DONE
    } bus_st_e;

    localparam int OFF_LOAD = 'h00;
    localparam int OFF_CUR  = 'h04;
    localparam int OFF_CTL  = 'h08;
    localparam int OFF_EOI  = 'h0C;
    localparam int OFF_STAT = 'h10;

    localparam int SOFF_RAW = 'h00;
    localparam int SOFF_MSK = 'h04;
    localparam int SOFF_VER = 'h0C;

    localparam int CB_EN   = 0;
    localparam int CB_MODE = 1;
    localparam int CB_MASK = 2;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rstn,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rstn) begin
        if (!rstn) begin
            meta <= '0;
            q_o  <= '0;
        end else begin
            meta <= d_i;
            q_o  <= meta;
        end
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int CNT_W = 32
) (
    input  logic             tclk,
    input  logic             trstn,
    input  logic             en_s,
    input  logic             mode_s,
    input  logic [CNT_W-1:0] load_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             evt_tgl_o
);
    logic en_d;

    always_ff @(posedge tclk or negedge trstn) begin
        if (!trstn) begin
            cnt_o     <= '0;
            en_d      <= 1'b0;
            evt_tgl_o <= 1'b0;
        end else begin
            en_d <= en_s;
            if (en_s && !en_d) begin
                cnt_o <= load_i;
            end else if (en_s) begin
                if (cnt_o == '0) begin
                    cnt_o     <= mode_s ? load_i : {CNT_W{1'b1}};
                    evt_tgl_o <= ~evt_tgl_o;
                end else begin
                    cnt_o <= cnt_o - 1'b1;
                end
            end
        end
    end

    p_load_on_rise_r3: assert property (@(posedge tclk) disable iff (!trstn)
        (en_s && !en_d) |=> (cnt_o == $past(load_i)));

    p_step_down_r3: assert property (@(posedge tclk) disable iff (!trstn)
        (en_s && en_d && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - 1'b1));

    p_reload_periodic_r4: assert property (@(posedge tclk) disable iff (!trstn)
        (en_s && en_d && mode_s && cnt_o == '0) |=> (cnt_o == $past(load_i)));

    p_reload_free_r5: assert property (@(posedge tclk) disable iff (!trstn)
        (en_s && en_d && !mode_s && cnt_o == '0) |=> (cnt_o == {CNT_W{1'b1}}));

    p_hold_disabled_r8: assert property (@(posedge tclk) disable iff (!trstn)
        !en_s |=> ($stable(cnt_o) && $stable(evt_tgl_o)));
endmodule

// File: rtl/tmr_snap.sv
module tmr_snap #(
    parameter int N_TMR = 8,
    parameter int CNT_W = 32,
    localparam int IDXW = $clog2(N_TMR)
) (
    input  logic                        tclk,
    input  logic                        trstn,
    input  logic                        req_tgl_i,
    input  logic [IDXW-1:0]             idx_i,
    input  logic [N_TMR-1:0][CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0]            snap_o,
    output logic                        ack_tgl_o
);
    logic req_s;
    logic req_d;

    tmr_sync #(.W(1)) u_req_sync (
        .clk  (tclk),
        .rstn (trstn),
        .d_i  (req_tgl_i),
        .q_o  (req_s)
    );

    always_ff @(posedge tclk or negedge trstn) begin
        if (!trstn) begin
            req_d     <= 1'b0;
            ack_tgl_o <= 1'b0;
            snap_o    <= '0;
        end else begin
            req_d <= req_s;
            if (req_s != req_d) begin
                snap_o    <= cnt_i[idx_i];
                ack_tgl_o <= ~ack_tgl_o;
            end
        end
    end

    p_ack_answers_req_r9: assert property (@(posedge tclk) disable iff (!trstn)
        (req_s != req_d) |=> (ack_tgl_o != $past(ack_tgl_o)));

    p_snap_stable_r9: assert property (@(posedge tclk) disable iff (!trstn)
        (req_s == req_d) |=> $stable(snap_o));
endmodule

// File: rtl/tmr_apb_regs.sv
module tmr_apb_regs
    import tmr_bank_pkg::*;
#(
    parameter int          N_TMR   = 8,
    parameter int          CNT_W   = 32,
    parameter int          ADDR_W  = 12,
    parameter int          BANK_SH = 5,
    parameter logic [31:0] VERSION = 32'h0001_0200,
    localparam int IDXW = $clog2(N_TMR),
    localparam int SHB  = BANK_SH + IDXW
) (
    input  logic                        pclk,
    input  logic                        presetn,
    input  logic                        psel,
    input  logic                        penable,
    input  logic                        pwrite,
    input  logic [ADDR_W-1:0]           paddr,
    input  logic [31:0]                 pwdata,
    output logic [31:0]                 prdata,
    output logic                        pready,
    input  logic [N_TMR-1:0]            evt_s_i,
    input  logic                        ack_s_i,
    input  logic [CNT_W-1:0]            snap_i,
    output logic                        req_tgl_o,
    output logic [IDXW-1:0]             idx_o,
    output logic [N_TMR-1:0]            en_o,
    output logic [N_TMR-1:0]            mode_o,
    output logic [N_TMR-1:0][CNT_W-1:0] load_o,
    output logic [N_TMR-1:0]            irq_o
);
    bus_st_e state, nxt;

    logic [N_TMR-1:0] mask_q;
    logic [N_TMR-1:0] raw_q;
    logic [N_TMR-1:0] evt_d;
    logic [N_TMR-1:0] set_v;
    logic [N_TMR-1:0] eoi_hit;
    logic [N_TMR-1:0] masked;
    logic             ack_seen;
    logic [CNT_W-1:0] hold_q;

    logic              access;
    logic              shared;
    logic [IDXW-1:0]   bank;
    logic [BANK_SH-1:0] off;
    logic              cur_rd;
    logic              idle_acc;

    assign access   = psel && penable;
    assign shared   = paddr[SHB];
    assign bank     = paddr[SHB-1:BANK_SH];
    assign off      = paddr[BANK_SH-1:0];
    assign cur_rd   = !pwrite && !shared && (int'(off) == OFF_CUR);
    assign idle_acc = (state == S_IDLE) && access;
    assign masked   = raw_q & ~mask_q;
    assign irq_o    = masked;

    // state register
    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) state <= S_IDLE;
        else          state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (access && cur_rd) nxt = S_WAIT;
            S_WAIT: if (ack_s_i != ack_seen) nxt = S_DONE;
            S_DONE: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // outputs of the bus machine
    always_comb begin
        pready = 1'b0;
        prdata = '0;
        unique case (state)
            S_IDLE: begin
                pready = access && !cur_rd;
                if (access && !pwrite) begin
                    if (shared) begin
                        case (int'(off))
                            SOFF_RAW: prdata = 32'(raw_q);
                            SOFF_MSK: prdata = 32'(masked);
                            SOFF_VER: prdata = VERSION;
                            default:  prdata = '0;
                        endcase
                    end else begin
                        case (int'(off))
                            OFF_LOAD: prdata = 32'(load_o[bank]);
                            OFF_CTL:  prdata = {29'd0, mask_q[bank], mode_o[bank], en_o[bank]};
                            OFF_STAT: prdata = {31'd0, masked[bank]};
                            default:  prdata = '0;
                        endcase
                    end
                end
            end
            S_WAIT: pready = 1'b0;
            S_DONE: begin
                pready = 1'b1;
                prdata = 32'(hold_q);
            end
            default: pready = 1'b0;
        endcase
    end

    // handshake side of the bus machine
    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            req_tgl_o <= 1'b0;
            idx_o     <= '0;
            ack_seen  <= 1'b0;
            hold_q    <= '0;
        end else begin
            if (state == S_IDLE && nxt == S_WAIT) begin
                req_tgl_o <= ~req_tgl_o;
                idx_o     <= bank;
            end
            if (state == S_WAIT && nxt == S_DONE) begin
                ack_seen <= ack_s_i;
                hold_q   <= snap_i;
            end
        end
    end

    // per-channel configuration and status
    genvar gi;
    generate
        for (gi = 0; gi < N_TMR; gi++) begin : g_ch
            logic sel_ch;
            assign sel_ch      = idle_acc && !shared && (bank == IDXW'(gi));
            assign eoi_hit[gi] = sel_ch && !pwrite && (int'(off) == OFF_EOI);
            assign set_v[gi]   = (evt_s_i[gi] ^ evt_d[gi]) && en_o[gi];

            always_ff @(posedge pclk or negedge presetn) begin
                if (!presetn) begin
                    load_o[gi] <= '0;
                    en_o[gi]   <= 1'b0;
                    mode_o[gi] <= 1'b0;
                    mask_q[gi] <= 1'b0;
                    raw_q[gi]  <= 1'b0;
                    evt_d[gi]  <= 1'b0;
                end else begin
                    evt_d[gi] <= evt_s_i[gi];
                    if (sel_ch && pwrite && int'(off) == OFF_LOAD)
                        load_o[gi] <= pwdata[CNT_W-1:0];
                    if (sel_ch && pwrite && int'(off) == OFF_CTL) begin
                        en_o[gi]   <= pwdata[CB_EN];
                        mode_o[gi] <= pwdata[CB_MODE];
                        mask_q[gi] <= pwdata[CB_MASK];
                    end
                    if (set_v[gi])
                        raw_q[gi] <= 1'b1;
                    else if (eoi_hit[gi] || !en_o[gi])
                        raw_q[gi] <= 1'b0;
                end
            end
        end
    endgenerate

    p_wait_stalls_r9: assert property (@(posedge pclk) disable iff (!presetn)
        (state == S_WAIT) |-> !pready);

    p_done_after_wait_r9: assert property (@(posedge pclk) disable iff (!presetn)
        (state == S_DONE) |-> ($past(state) == S_WAIT));

    p_eoi_clears_r7: assert property (@(posedge pclk) disable iff (!presetn)
        ((eoi_hit != '0) && ((eoi_hit & set_v) == '0)) |=> ((raw_q & $past(eoi_hit)) == '0));

    p_disable_clears_r8: assert property (@(posedge pclk) disable iff (!presetn)
        (en_o != '1) |=> ((raw_q & ~$past(en_o)) == '0));

    p_irq_onehot_access_r2: assert property (@(posedge pclk) disable iff (!presetn)
        $onehot0(eoi_hit));
endmodule

// File: rtl/apb_countdown_bank.sv
module apb_countdown_bank #(
    parameter int          N_TMR   = 8,
    parameter int          CNT_W   = 32,
    parameter int          ADDR_W  = 12,
    parameter int          BANK_SH = 5,
    parameter logic [31:0] VERSION = 32'h0001_0200,
    localparam int IDXW = $clog2(N_TMR)
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    input  logic              tclk,
    input  logic              trstn,
    output logic [N_TMR-1:0]  irq_o
);
    logic [N_TMR-1:0]            en_b, mode_b, en_t, mode_t;
    logic [N_TMR-1:0][CNT_W-1:0] load_b, cnt_t;
    logic [N_TMR-1:0]            evt_t, evt_b;
    logic                        req_b, ack_t, ack_b;
    logic [IDXW-1:0]             idx_b;
    logic [CNT_W-1:0]            snap_t;

    tmr_apb_regs #(
        .N_TMR(N_TMR), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
        .BANK_SH(BANK_SH), .VERSION(VERSION)
    ) u_regs (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .evt_s_i(evt_b), .ack_s_i(ack_b), .snap_i(snap_t),
        .req_tgl_o(req_b), .idx_o(idx_b), .en_o(en_b), .mode_o(mode_b),
        .load_o(load_b), .irq_o(irq_o)
    );

    tmr_sync #(.W(N_TMR)) u_en_sync   (.clk(tclk), .rstn(trstn), .d_i(en_b),   .q_o(en_t));
    tmr_sync #(.W(N_TMR)) u_mode_sync (.clk(tclk), .rstn(trstn), .d_i(mode_b), .q_o(mode_t));
    tmr_sync #(.W(N_TMR)) u_evt_sync  (.clk(pclk), .rstn(presetn), .d_i(evt_t), .q_o(evt_b));
    tmr_sync #(.W(1))     u_ack_sync  (.clk(pclk), .rstn(presetn), .d_i(ack_t), .q_o(ack_b));

    genvar gi;
    generate
        for (gi = 0; gi < N_TMR; gi++) begin : g_core
            tmr_core #(.CNT_W(CNT_W)) u_core (
                .tclk(tclk), .trstn(trstn), .en_s(en_t[gi]), .mode_s(mode_t[gi]),
                .load_i(load_b[gi]), .cnt_o(cnt_t[gi]), .evt_tgl_o(evt_t[gi])
            );
        end
    endgenerate

    tmr_snap #(.N_TMR(N_TMR), .CNT_W(CNT_W)) u_snap (
        .tclk(tclk), .trstn(trstn), .req_tgl_i(req_b), .idx_i(idx_b),
        .cnt_i(cnt_t), .snap_o(snap_t), .ack_tgl_o(ack_t)
    );
endmodule

// File: tb/apb_countdown_bank_tb.sv
`timescale 1ns/1ps
module apb_countdown_bank_tb_top;
    logic        pclk = 1'b0;
    logic        tclk = 1'b0;
    logic        presetn = 1'b0;
    logic        trstn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [7:0]  irq_o;

    int checks = 0;
    int errors = 0;
    bit run_done = 1'b0;
    bit mon_on = 1'b0;
    int shadow_mask[8];

    always #5 pclk = ~pclk;
    initial begin
        #3;
        forever #15 tclk = ~tclk;
    end

    apb_countdown_bank dut_i (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .tclk(tclk), .trstn(trstn), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input logic [31:0] act,
                             input logic [31:0] lo, input logic [31:0] hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h..%h", req, act, lo, hi);
        end
    endtask

    task automatic apb(input logic wr, input logic [11:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output int waits);
        logic rdy;
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd;
        @(negedge pclk);
        penable = 1'b1;
        waits = 0;
        do begin
            #1;
            rdy = pready;
            rd  = prdata;
            if (!rdy) waits++;
            @(negedge pclk);
        end while (!rdy);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr32(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] r; int w;
        apb(1'b1, a, d, r, w);
        if (a[11:8] == 4'h0 && a[4:0] == 5'h08) shadow_mask[a[7:5]] = int'(d[2]);
    endtask

    task automatic rd32(input logic [11:0] a, output logic [31:0] d);
        int w;
        apb(1'b0, a, 32'h0, d, w);
    endtask

    task automatic wait_irq(input int ch, output realtime t);
        int n = 0;
        while (irq_o[ch] !== 1'b1 && n < 5000) begin
            @(negedge pclk);
            n++;
        end
        t = $realtime;
    endtask

    // per-clock reference monitor: masked or idle channels never interrupt (R6)
    always @(negedge pclk) begin
        if (mon_on) begin
            for (int i = 0; i < 8; i++) begin
                bit exp_quiet;
                exp_quiet = (shadow_mask[i] != 0) || (i >= 4);
                checks++;
                if (exp_quiet && irq_o[i] !== 1'b0) begin
                    errors++;
                    $display("FAIL R6 monitor ch%0d actual=%b expected=0", i, irq_o[i]);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!run_done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, a, b;
        int w;
        realtime t1, t2;
        for (int i = 0; i < 8; i++) shadow_mask[i] = 0;
        repeat (4) @(negedge pclk);
        presetn = 1'b1; trstn = 1'b1;
        repeat (4) @(negedge pclk);

        // R1 reset state
        check("R1 irq", 32'(irq_o), 32'h0);
        rd32(12'h100, r); check("R1 raw", r, 32'h0);
        rd32(12'h008, r); check("R1 ctl0", r, 32'h0);
        rd32(12'h0E8, r); check("R1 ctl7", r, 32'h0);
        // R2 version and load readback
        rd32(12'h10C, r); check("R2 version", r, 32'h0001_0200);
        wr32(12'h0A0, 32'h1234_5678);
        rd32(12'h0A0, r); check("R2 load5 readback", r, 32'h1234_5678);
        mon_on = 1'b1;

        // R3 enable edge loads, counts down
        wr32(12'h060, 32'd1000);
        wr32(12'h068, 32'h6);        // periodic, masked, disabled
        wr32(12'h068, 32'h7);        // enable
        apb(1'b0, 12'h064, 32'h0, a, w);
        check_rng("R3 loaded value", a, 32'd950, 32'd1000);
        check_rng("R9 wait states", 32'(w), 32'd3, 32'd40);
        #600;
        rd32(12'h064, b);
        check_rng("R3 decrement", a - b, 32'd18, 32'd24);

        // R8 disabled channel holds
        wr32(12'h068, 32'h6);
        #200;
        rd32(12'h064, a);
        #400;
        rd32(12'h064, b);
        check("R8 hold value", b, a);

        // R4 periodic spacing on channel 0, load 20
        wr32(12'h000, 32'd20);
        wr32(12'h008, 32'h3);
        wait_irq(0, t1);
        check("R4 first irq", 32'(irq_o[0]), 32'h1);
        rd32(12'h064, r);            // unrelated access
        rd32(12'h00C, r); check("R7 eoi returns zero", r, 32'h0);
        @(negedge pclk);
        check("R7 eoi clears irq", 32'(irq_o[0]), 32'h0);
        wait_irq(0, t2);
        check_rng("R4 period ns", 32'(int'(t2 - t1)), 32'd590, 32'd670);
        rd32(12'h004, r);
        check_rng("R9 coherent periodic value", r, 32'd0, 32'd20);
        rd32(12'h010, r); check("R2 channel status", r, 32'h1);

        // R8 disable clears pending, no new status
        wr32(12'h008, 32'h2);
        @(negedge pclk);
        check("R8 irq after disable", 32'(irq_o[0]), 32'h0);
        #1500;
        rd32(12'h100, r); check("R8 raw stays clear", r & 32'h1, 32'h0);

        // R5/R6 free-running, masked, channel 1
        wr32(12'h020, 32'd10);
        wr32(12'h028, 32'h4);
        wr32(12'h028, 32'h5);
        #900;
        rd32(12'h100, r); check("R6 raw set while masked", r & 32'h2, 32'h2);
        check("R6 irq quiet while masked", 32'(irq_o[1]), 32'h0);
        rd32(12'h104, r); check("R6 masked status", r & 32'h2, 32'h0);
        rd32(12'h024, a);
        check_rng("R5 reload all ones", a, 32'hFFFF_F000, 32'hFFFF_FFFF);
        wr32(12'h028, 32'h1);        // unmask, enable kept
        @(negedge pclk);
        check("R6 unmask raises irq", 32'(irq_o[1]), 32'h1);
        rd32(12'h02C, r); check("R7 eoi ch1 zero", r, 32'h0);
        @(negedge pclk);
        check("R7 eoi ch1 clears", 32'(irq_o[1]), 32'h0);
        #300;
        rd32(12'h024, b);
        check_rng("R7 counter keeps running", a - b, 32'd5, 32'd40);

        run_done = 1'b1;
        mon_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule